// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block sits between a register bus and the protocol engine of a CAN controller. It holds three transmit mailboxes. Each mailbox has an identifier word, a length word and two data words. Software fills a mailbox and then sets the request bit in its identifier word, which makes the mailbox pending. While the engine side is idle, an arbiter picks one pending mailbox and offers its frame fields to the engine. The engine answers with a one-cycle grant, and later with a one-cycle done or fail pulse.

One configuration bit sets the arbitration order. When it is clear, the lowest identifier wins. When it is set, the oldest request wins. A second configuration bit controls retransmission. With retransmission on, a failed frame stays pending and is offered again. With it off, a failed frame is retired and flagged. Each mailbox reports its outcome through completion and failure flags in a status word, with the flags for mailbox n placed in byte n. Software clears a flag by writing 1 to it. A transmit interrupt is raised while any completion flag is set and the interrupt enable bit is set.

Top module: `can_txmb_sched`

## Requirements
- R1: After reset no mailbox is pending, `eng_valid` and `tx_irq` are low, and the status word at address 1 reads 0.
- R2: Mailbox n has its identifier word at address 4+4n, its length word (data length code in bits 3:0) at 5+4n, and its data words at 6+4n (low) and 7+4n (high). Writing the identifier word of an idle mailbox with bit 0 set makes it pending, and bit 0 then reads back as 1. If the engine side is idle, `eng_valid` rises on the second rising edge after the write edge and presents that mailbox's index, identifier bits 31:1, length code and data.
- R3: When control bit 0 (address 0) is clear, the offered mailbox is the pending one whose identifier bits 31:1 are the smallest unsigned value. On equal values, the lower mailbox index wins.
- R4: When control bit 0 is set, the offered mailbox is the pending one whose request was accepted first.
- R5: A done pulse while a frame is granted sets completion flag bit 8n of the status word for that mailbox and ends its pending state, so identifier bit 0 reads back as 0.
- R6: When control bit 1 is clear, a fail pulse leaves the mailbox pending with no completion flag set, and the mailbox is offered again.
- R7: When control bit 1 is set, a fail pulse sets completion bit 8n and failure bit 8n+1 and ends the pending state.
- R8: Writing the status word clears each completion or failure flag whose bit is written as 1 and leaves flags written as 0 unchanged. A new outcome in the same cycle takes precedence over the clear.
- R9: A write to the identifier word of a pending mailbox is ignored, both in the readback and in the identifier that is offered.
- R10: `tx_irq` is high exactly while bit 0 of the interrupt enable word (address 2) is set and at least one completion flag is set.
- R11: Once `eng_valid` is high, it stays high with the same mailbox and fields until a grant is taken. No mailbox is offered while a granted frame is outstanding.
- R12: A done pulse clears the failure flag of that mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| eng_valid | output | 1 | A frame is offered to the engine |
| eng_mbx | output | IDX_W | Index of the offered mailbox |
| eng_idw | output | 31 | Identifier word bits 31:1 of the offered mailbox |
| eng_dlc | output | 4 | Data length code of the offered mailbox |
| eng_data | output | 64 | Data words of the offered mailbox, high word on top |
| eng_grant | input | 1 | Engine accepts the offered frame |
| eng_done | input | 1 | Granted frame went out successfully |
| eng_fail | input | 1 | Granted frame attempt failed |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The assertions assume that the engine raises a grant only while a frame is offered. They also assume that done and fail arrive only while a granted frame is outstanding, and never both in the same cycle. The bench engine follows the same rule. It raises a grant only after it has seen `eng_valid` high, and it sends exactly one done or fail pulse per grant. It queues competing requests while a frame is outstanding, so the arbiter has several candidates to choose from at the moment the engine becomes free.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_OFFER = 2'd1,
      ST_BUSY  = 2'd2
   } eng_state_t;

   localparam int REG_CTRL  = 0;
   localparam int REG_STAT  = 1;
   localparam int REG_IEN   = 2;
   localparam int MBX_BASE  = 4;
   localparam int MBX_WORDS = 4;

   localparam int CTRL_ORDER_BIT = 0;
   localparam int CTRL_NORTX_BIT = 1;

   localparam int KEY_W = 31;

endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot #(
   parameter int RANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_id,
   input  logic              wr_len,
   input  logic              wr_dlo,
   input  logic              wr_dhi,
   input  logic [31:0]       wdata,
   input  logic              self_rel,
   input  logic              any_rel,
   input  logic [RANK_W-1:0] rel_rank,
   input  logic [RANK_W-1:0] new_rank,
   output logic [30:0]       idw_q,
   output logic [3:0]        dlc_q,
   output logic [31:0]       dlo_q,
   output logic [31:0]       dhi_q,
   output logic              pend_q,
   output logic [RANK_W-1:0] rank_q
);

   logic take_id;
   assign take_id = wr_id && !pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idw_q  <= '0;
         dlc_q  <= '0;
         dlo_q  <= '0;
         dhi_q  <= '0;
         pend_q <= 1'b0;
         rank_q <= '0;
      end else begin
         if (take_id) idw_q <= wdata[31:1];
         if (wr_len)  dlc_q <= wdata[3:0];
         if (wr_dlo)  dlo_q <= wdata;
         if (wr_dhi)  dhi_q <= wdata;
         if (take_id && wdata[0]) begin
            pend_q <= 1'b1;
            rank_q <= new_rank;
         end else if (self_rel) begin
            pend_q <= 1'b0;
         end else if (pend_q && any_rel && (rank_q > rel_rank)) begin
            rank_q <= rank_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/can_txmb_arb.sv
module can_txmb_arb #(
   parameter int N      = 3,
   parameter int RANK_W = 2,
   parameter int IDX_W  = 2
) (
   input  logic [N-1:0]             pend,
   input  logic [N-1:0][RANK_W-1:0] rank,
   input  logic [N-1:0][30:0]       key,
   input  logic                     order_mode,
   output logic [IDX_W-1:0]         win,
   output logic                     any
);

   logic [30:0] best;

   always_comb begin
      win  = '0;
      any  = 1'b0;
      best = '1;
      for (int i = 0; i < N; i++) begin
         if (pend[i]) begin
            if (order_mode) begin
               if (rank[i] == '0) win = IDX_W'(i);
            end else if (!any || (key[i] < best)) begin
               win  = IDX_W'(i);
               best = key[i];
            end
            any = 1'b1;
         end
      end
   end

endmodule

// File: rtl/can_txmb_stat.sv
module can_txmb_stat #(
   parameter int N     = 3,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_we,
   input  logic [31:0]      clr_data,
   input  logic             ev_en,
   input  logic             ev_fail,
   input  logic [IDX_W-1:0] ev_idx,
   input  logic             ien,
   output logic [N-1:0]     cmpl_q,
   output logic [N-1:0]     fail_q,
   output logic             irq
);

   for (genvar n = 0; n < N; n++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cmpl_q[n] <= 1'b0;
            fail_q[n] <= 1'b0;
         end else begin
            if (clr_we && clr_data[8*n])   cmpl_q[n] <= 1'b0;
            if (clr_we && clr_data[8*n+1]) fail_q[n] <= 1'b0;
            if (ev_en && (ev_idx == IDX_W'(n))) begin
               cmpl_q[n] <= 1'b1;
               fail_q[n] <= ev_fail;
            end
         end
      end
   end

   assign irq = ien && (|cmpl_q);

endmodule

// File: rtl/can_txmb_fsm.sv
module can_txmb_fsm
   import can_txmb_pkg::*;
#(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_pend,
   input  logic [IDX_W-1:0] win,
   input  logic             eng_grant,
   input  logic             eng_done,
   input  logic             eng_fail,
   input  logic             no_retx,
   output logic             eng_valid,
   output logic             busy,
   output logic [IDX_W-1:0] sel_q,
   output logic             ev_en,
   output logic             ev_fail
);

   eng_state_t state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sel_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (any_pend) begin
               sel_q   <= win;
               state_q <= ST_OFFER;
            end
            ST_OFFER: if (eng_grant) state_q <= ST_BUSY;
            ST_BUSY:  if (eng_done || eng_fail) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign eng_valid = (state_q == ST_OFFER);
   assign busy      = (state_q == ST_BUSY);
   assign ev_en     = busy && (eng_done || (eng_fail && no_retx));
   assign ev_fail   = eng_fail && !eng_done;

endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched
   import can_txmb_pkg::*;
#(
   parameter  int NUM_MBX = 3,
   parameter  int ADDR_W  = 4,
   localparam int IDX_W   = (NUM_MBX > 1) ? $clog2(NUM_MBX) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              eng_valid,
   output logic [IDX_W-1:0]  eng_mbx,
   output logic [30:0]       eng_idw,
   output logic [3:0]        eng_dlc,
   output logic [63:0]       eng_data,
   input  logic              eng_grant,
   input  logic              eng_done,
   input  logic              eng_fail,
   output logic              tx_irq
);

   localparam int CNT_W    = $clog2(NUM_MBX + 1);
   localparam int RANK_W   = CNT_W;
   localparam int MAP_SIZE = MBX_BASE + MBX_WORDS * NUM_MBX;

   if (NUM_MBX < 1 || NUM_MBX > 4) begin : g_bad_count
      $error("NUM_MBX must be 1 to 4: status flags sit one byte apart");
   end
   if ((1 << ADDR_W) < MAP_SIZE) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic                     order_q;
   logic                     noretx_q;
   logic                     ien_q;

   logic [NUM_MBX-1:0]              pend;
   logic [NUM_MBX-1:0][RANK_W-1:0]  rank;
   logic [NUM_MBX-1:0][30:0]        idw;
   logic [NUM_MBX-1:0][3:0]         dlc;
   logic [NUM_MBX-1:0][31:0]        dlo;
   logic [NUM_MBX-1:0][31:0]        dhi;
   logic [NUM_MBX-1:0]              cmpl;
   logic [NUM_MBX-1:0]              fail;

   logic [IDX_W-1:0]  win;
   logic              any_pend;
   logic              busy;
   logic [IDX_W-1:0]  sel_q;
   logic              ev_en;
   logic              ev_fail;
   logic [CNT_W-1:0]  pend_cnt;
   logic [RANK_W-1:0] new_rank;
   logic [RANK_W-1:0] rel_rank;
   logic              wr_stat;

   // control words
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         order_q  <= 1'b0;
         noretx_q <= 1'b0;
         ien_q    <= 1'b0;
      end else if (bus_we) begin
         if (bus_addr == ADDR_W'(REG_CTRL)) begin
            order_q  <= bus_wdata[CTRL_ORDER_BIT];
            noretx_q <= bus_wdata[CTRL_NORTX_BIT];
         end
         if (bus_addr == ADDR_W'(REG_IEN)) ien_q <= bus_wdata[0];
      end
   end

   assign wr_stat = bus_we && (bus_addr == ADDR_W'(REG_STAT));

   // request-age bookkeeping: a new request ranks behind all still pending
   always_comb begin
      pend_cnt = '0;
      for (int i = 0; i < NUM_MBX; i++) pend_cnt = pend_cnt + CNT_W'(pend[i]);
   end
   assign new_rank = RANK_W'(pend_cnt) - RANK_W'(ev_en);
   assign rel_rank = rank[sel_q];

   for (genvar n = 0; n < NUM_MBX; n++) begin : g_mbx
      localparam int BASE = MBX_BASE + MBX_WORDS * n;
      logic wr_id, wr_len, wr_dlo, wr_dhi, self_rel;
      assign wr_id    = bus_we && (bus_addr == ADDR_W'(BASE));
      assign wr_len   = bus_we && (bus_addr == ADDR_W'(BASE + 1));
      assign wr_dlo   = bus_we && (bus_addr == ADDR_W'(BASE + 2));
      assign wr_dhi   = bus_we && (bus_addr == ADDR_W'(BASE + 3));
      assign self_rel = ev_en && (sel_q == IDX_W'(n));

      can_txmb_slot #(.RANK_W(RANK_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_id    (wr_id),
         .wr_len   (wr_len),
         .wr_dlo   (wr_dlo),
         .wr_dhi   (wr_dhi),
         .wdata    (bus_wdata),
         .self_rel (self_rel),
         .any_rel  (ev_en),
         .rel_rank (rel_rank),
         .new_rank (new_rank),
         .idw_q    (idw[n]),
         .dlc_q    (dlc[n]),
         .dlo_q    (dlo[n]),
         .dhi_q    (dhi[n]),
         .pend_q   (pend[n]),
         .rank_q   (rank[n])
      );
   end

   can_txmb_arb #(.N(NUM_MBX), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_arb (
      .pend       (pend),
      .rank       (rank),
      .key        (idw),
      .order_mode (order_q),
      .win        (win),
      .any        (any_pend)
   );

   can_txmb_fsm #(.IDX_W(IDX_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_pend  (any_pend),
      .win       (win),
      .eng_grant (eng_grant),
      .eng_done  (eng_done),
      .eng_fail  (eng_fail),
      .no_retx   (noretx_q),
      .eng_valid (eng_valid),
      .busy      (busy),
      .sel_q     (sel_q),
      .ev_en     (ev_en),
      .ev_fail   (ev_fail)
   );

   can_txmb_stat #(.N(NUM_MBX), .IDX_W(IDX_W)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_we   (wr_stat),
      .clr_data (bus_wdata),
      .ev_en    (ev_en),
      .ev_fail  (ev_fail),
      .ev_idx   (sel_q),
      .ien      (ien_q),
      .cmpl_q   (cmpl),
      .fail_q   (fail),
      .irq      (tx_irq)
   );

   assign eng_mbx  = sel_q;
   assign eng_idw  = idw[sel_q];
   assign eng_dlc  = dlc[sel_q];
   assign eng_data = {dhi[sel_q], dlo[sel_q]};

   // register read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(REG_CTRL)) begin
         bus_rdata[CTRL_ORDER_BIT] = order_q;
         bus_rdata[CTRL_NORTX_BIT] = noretx_q;
      end else if (bus_addr == ADDR_W'(REG_STAT)) begin
         for (int n = 0; n < NUM_MBX; n++) begin
            bus_rdata[8*n]   = cmpl[n];
            bus_rdata[8*n+1] = fail[n];
         end
      end else if (bus_addr == ADDR_W'(REG_IEN)) begin
         bus_rdata[0] = ien_q;
      end else begin
         for (int n = 0; n < NUM_MBX; n++) begin
            if (bus_addr == ADDR_W'(MBX_BASE + MBX_WORDS * n))     bus_rdata = {idw[n], pend[n]};
            if (bus_addr == ADDR_W'(MBX_BASE + MBX_WORDS * n + 1)) bus_rdata = {28'd0, dlc[n]};
            if (bus_addr == ADDR_W'(MBX_BASE + MBX_WORDS * n + 2)) bus_rdata = dlo[n];
            if (bus_addr == ADDR_W'(MBX_BASE + MBX_WORDS * n + 3)) bus_rdata = dhi[n];
         end
      end
   end

endmodule

// File: rtl/can_txmb_chk.sv
module can_txmb_chk #(
   parameter int N     = 3,
   parameter int IDX_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             eng_valid,
   input logic             eng_grant,
   input logic             eng_done,
   input logic             eng_fail,
   input logic [IDX_W-1:0] eng_mbx,
   input logic [30:0]      eng_idw,
   input logic             busy,
   input logic [IDX_W-1:0] sel,
   input logic [N-1:0]     pend,
   input logic [N-1:0]     cmpl,
   input logic [N-1:0]     fail,
   input logic             no_retx,
   input logic             tx_irq
);

   a_r11_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
      eng_valid && !eng_grant |=> eng_valid && $stable(eng_mbx) && $stable(eng_idw));

   a_r11_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_valid && busy));

   // R5 and R12
   a_r5_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
      busy && eng_done |=> cmpl[$past(sel)] && !pend[$past(sel)] && !fail[$past(sel)]);

   a_r6_retry_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      busy && eng_fail && !eng_done && !no_retx |=> pend[$past(sel)]);

   a_r7_fail_final: assert property (@(posedge clk) disable iff (!rst_n)
      busy && eng_fail && !eng_done && no_retx |=>
         cmpl[$past(sel)] && fail[$past(sel)] && !pend[$past(sel)]);

   a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> (|cmpl));

endmodule

bind can_txmb_sched can_txmb_chk #(.N(NUM_MBX), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .eng_valid (eng_valid),
   .eng_grant (eng_grant),
   .eng_done  (eng_done),
   .eng_fail  (eng_fail),
   .eng_mbx   (eng_mbx),
   .eng_idw   (eng_idw),
   .busy      (busy),
   .sel       (sel_q),
   .pend      (pend),
   .cmpl      (cmpl),
   .fail      (fail),
   .no_retx   (noretx_q),
   .tx_irq    (tx_irq)
);

// File: tb/sim_can_txmb_sched.sv
module sim_can_txmb_sched;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        eng_valid;
   logic [1:0]  eng_mbx;
   logic [30:0] eng_idw;
   logic [3:0]  eng_dlc;
   logic [63:0] eng_data;
   logic        eng_grant = 1'b0;
   logic        eng_done = 1'b0;
   logic        eng_fail = 1'b0;
   logic        tx_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   can_txmb_sched u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_valid(eng_valid),
      .eng_mbx(eng_mbx), .eng_idw(eng_idw), .eng_dlc(eng_dlc),
      .eng_data(eng_data), .eng_grant(eng_grant), .eng_done(eng_done),
      .eng_fail(eng_fail), .tx_irq(tx_irq)
   );

   // behavioural reference model
   bit          m_pend [3];
   logic [31:0] m_id   [3];
   bit          m_cmpl [3];
   bit          m_fail [3];
   bit          m_order, m_noretx, m_ien;
   int          m_state;   // 0 idle, 1 offering, 2 granted
   int          m_sel;
   int          m_q [$];

   function automatic int pick();
      int b = -1;
      if (m_order) return (m_q.size() > 0) ? m_q[0] : 0;
      for (int i = 0; i < 3; i++)
         if (m_pend[i] && (b < 0 || m_id[i][31:1] < m_id[b][31:1])) b = i;
      return (b < 0) ? 0 : b;
   endfunction

   function automatic logic [31:0] mstat();
      logic [31:0] w = '0;
      for (int n = 0; n < 3; n++) begin
         w[8*n]   = m_cmpl[n];
         w[8*n+1] = m_fail[n];
      end
      return w;
   endfunction

   int  t_win, t_state, t_idx, t_word;
   bit  t_any, t_rel;
   bit  t_pold [3];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin
            m_pend[i] = 0; m_id[i] = '0; m_cmpl[i] = 0; m_fail[i] = 0;
         end
         m_order = 0; m_noretx = 0; m_ien = 0; m_state = 0; m_sel = 0;
         m_q.delete();
      end else begin
         t_win = pick();
         t_state = m_state;
         t_any = 0;
         for (int i = 0; i < 3; i++) begin
            t_pold[i] = m_pend[i];
            if (m_pend[i]) t_any = 1;
         end
         t_rel = (t_state == 2) && (eng_done || (eng_fail && m_noretx));
         if (bus_we && bus_addr == 4'd1)
            for (int n = 0; n < 3; n++) begin
               if (bus_wdata[8*n])   m_cmpl[n] = 0;
               if (bus_wdata[8*n+1]) m_fail[n] = 0;
            end
         if (t_rel) begin
            m_cmpl[m_sel] = 1;
            m_fail[m_sel] = !eng_done;
            m_pend[m_sel] = 0;
            for (int k = 0; k < m_q.size(); k++)
               if (m_q[k] == m_sel) begin m_q.delete(k); break; end
         end
         if (bus_we && bus_addr == 4'd0) begin
            m_order = bus_wdata[0]; m_noretx = bus_wdata[1];
         end
         if (bus_we && bus_addr == 4'd2) m_ien = bus_wdata[0];
         if (bus_we && bus_addr >= 4'd4) begin
            t_idx = (int'(bus_addr) - 4) / 4;
            t_word = int'(bus_addr) % 4;
            if (t_word == 0 && !t_pold[t_idx]) begin
               m_id[t_idx] = bus_wdata;
               if (bus_wdata[0]) begin
                  m_pend[t_idx] = 1;
                  m_q.push_back(t_idx);
               end
            end
         end
         case (t_state)
            0: if (t_any) begin m_sel = t_win; m_state = 1; end
            1: if (eng_grant) m_state = 2;
            default: if (eng_done || eng_fail) m_state = 0;
         endcase
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // cycle compare against model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(eng_valid === (m_state == 1), "R11 offer phase", 64'(eng_valid), 64'(m_state == 1));
         if (m_state == 1) begin
            chk(eng_mbx === 2'(m_sel), "R3 offered mailbox", 64'(eng_mbx), 64'(m_sel));
            chk(eng_idw === m_id[m_sel][31:1], "R9 offered identifier", 64'(eng_idw), 64'(m_id[m_sel][31:1]));
         end
         chk(tx_irq === (m_ien && (m_cmpl[0] || m_cmpl[1] || m_cmpl[2])), "R10 irq",
             64'(tx_irq), 64'(m_ien && (m_cmpl[0] || m_cmpl[1] || m_cmpl[2])));
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse_grant();
      @(negedge clk); eng_grant = 1'b1;
      @(negedge clk); eng_grant = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk); eng_done = 1'b1;
      @(negedge clk); eng_done = 1'b0;
   endtask

   task automatic pulse_fail();
      @(negedge clk); eng_fail = 1'b1;
      @(negedge clk); eng_fail = 1'b0;
   endtask

   task automatic wait_valid();
      for (int i = 0; i < 20; i++) begin
         if (eng_valid) break;
         @(negedge clk);
      end
   endtask

   task automatic expect_offer(input int mbx, input string tag);
      wait_valid();
      chk(eng_valid === 1'b1 && eng_mbx === 2'(mbx), tag, 64'(eng_mbx), 64'(mbx));
   endtask

   task automatic check_stat(input string tag);
      logic [31:0] v;
      rd(4'd1, v);
      chk(v === mstat(), tag, 64'(v), 64'(mstat()));
   endtask

   function automatic logic [31:0] sid(input int id);
      return 32'(id) << 21;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd1, v);
      chk(v === 32'd0, "R1 status after reset", 64'(v), 0);
      chk(eng_valid === 1'b0, "R1 no offer after reset", 64'(eng_valid), 0);
      chk(tx_irq === 1'b0, "R1 irq after reset", 64'(tx_irq), 0);
      rd(4'd4, v);
      chk(v[0] === 1'b0, "R1 mailbox idle after reset", 64'(v[0]), 0);

      // R2 load and request mailbox 0
      wr(4'd2, 32'd1);
      wr(4'd5, 32'd8);
      wr(4'd6, 32'h1122_3344);
      wr(4'd7, 32'h5566_7788);
      wr(4'd4, sid(12'h123) | 32'd1);
      chk(eng_valid === 1'b0, "R2 not yet offered", 64'(eng_valid), 0);
      rd(4'd4, v);
      chk(v === (sid(12'h123) | 32'd1), "R2 request readback", 64'(v), 64'(sid(12'h123) | 32'd1));
      chk(eng_valid === 1'b1 && eng_mbx === 2'd0, "R2 offered on second edge", 64'(eng_valid), 1);
      chk(eng_dlc === 4'd8, "R2 length code", 64'(eng_dlc), 8);
      chk(eng_data === 64'h5566_7788_1122_3344, "R2 data", eng_data, 64'h5566_7788_1122_3344);

      // R11 hold without grant
      repeat (4) @(negedge clk);
      chk(eng_valid === 1'b1 && eng_mbx === 2'd0, "R11 offer held", 64'(eng_mbx), 0);

      // R5 completion, R10 irq, R8 clear
      pulse_grant();
      pulse_done();
      rd(4'd4, v);
      chk(v[0] === 1'b0, "R5 request cleared", 64'(v[0]), 0);
      rd(4'd1, v);
      chk(v[0] === 1'b1, "R5 completion flag", 64'(v), 1);
      chk(tx_irq === 1'b1, "R10 irq with flag", 64'(tx_irq), 1);
      wr(4'd2, 32'd0);
      @(negedge clk);
      chk(tx_irq === 1'b0, "R10 irq masked", 64'(tx_irq), 0);
      wr(4'd2, 32'd1);
      wr(4'd1, 32'd0);
      rd(4'd1, v);
      chk(v[0] === 1'b1, "R8 zero write keeps flag", 64'(v), 1);
      wr(4'd1, 32'd1);
      rd(4'd1, v);
      chk(v === 32'd0, "R8 one write clears flag", 64'(v), 0);
      chk(tx_irq === 1'b0, "R10 irq after clear", 64'(tx_irq), 0);

      // R3 identifier priority, R9 ignored rewrite
      wr(4'd0, 32'd0);
      wr(4'd4, sid(12'h300) | 32'd1);
      expect_offer(0, "R3 single request");
      pulse_grant();
      wr(4'd8,  sid(12'h200) | 32'd1);
      wr(4'd12, sid(12'h100) | 32'd1);
      wr(4'd8,  sid(12'h050) | 32'd1);
      rd(4'd8, v);
      chk(v === (sid(12'h200) | 32'd1), "R9 pending id kept", 64'(v), 64'(sid(12'h200) | 32'd1));
      pulse_done();
      expect_offer(2, "R3 lowest identifier first");
      pulse_grant(); pulse_done();
      expect_offer(1, "R3 next identifier");
      chk(eng_idw === sid(12'h200) >> 1, "R9 offered id unchanged", 64'(eng_idw), 64'(sid(12'h200) >> 1));
      pulse_grant(); pulse_done();
      check_stat("R5 three completions");
      wr(4'd1, 32'h0001_0101);

      // R3 tie goes to lower index
      wr(4'd4, sid(12'h300) | 32'd1);
      expect_offer(0, "R3 tie setup");
      pulse_grant();
      wr(4'd12, sid(12'h111) | 32'd1);
      wr(4'd8,  sid(12'h111) | 32'd1);
      pulse_done();
      expect_offer(1, "R3 tie lower index");
      pulse_grant(); pulse_done();
      expect_offer(2, "R3 tie second");
      pulse_grant(); pulse_done();

      // R4 request order
      wr(4'd0, 32'd1);
      wr(4'd4, sid(12'h010) | 32'd1);
      expect_offer(0, "R4 setup");
      pulse_grant();
      wr(4'd12, sid(12'h700) | 32'd1);
      wr(4'd8,  sid(12'h100) | 32'd1);
      pulse_done();
      expect_offer(2, "R4 oldest request first");
      pulse_grant(); pulse_done();
      expect_offer(1, "R4 younger request second");
      pulse_grant(); pulse_done();
      wr(4'd1, 32'h0003_0303);

      // R6 retry
      wr(4'd0, 32'd0);
      wr(4'd4, sid(12'h0AA) | 32'd1);
      expect_offer(0, "R6 setup");
      pulse_grant(); pulse_fail();
      rd(4'd4, v);
      chk(v[0] === 1'b1, "R6 still pending", 64'(v[0]), 1);
      rd(4'd1, v);
      chk(v === 32'd0, "R6 no completion", 64'(v), 0);
      expect_offer(0, "R6 offered again");
      pulse_grant(); pulse_done();
      wr(4'd1, 32'd1);

      // R7 no retransmission
      wr(4'd0, 32'd2);
      wr(4'd8, sid(12'h0BB) | 32'd1);
      expect_offer(1, "R7 setup");
      pulse_grant(); pulse_fail();
      rd(4'd1, v);
      chk(v === 32'h0000_0300, "R7 completion and failure", 64'(v), 64'h300);
      rd(4'd8, v);
      chk(v[0] === 1'b0, "R7 request cleared", 64'(v[0]), 0);
      repeat (3) @(negedge clk);
      chk(eng_valid === 1'b0, "R7 not offered again", 64'(eng_valid), 0);

      // R12 success clears failure flag
      wr(4'd0, 32'd0);
      wr(4'd8, sid(12'h0BB) | 32'd1);
      expect_offer(1, "R12 setup");
      pulse_grant(); pulse_done();
      rd(4'd1, v);
      chk(v === 32'h0000_0100, "R12 failure cleared", 64'(v), 64'h100);
      check_stat("R8 status matches");

      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule